// File: doc/BRIEF.md
# Power-Up Reset Sequencer

This block gathers every reset request of a small microcontroller into one internal core reset and then keeps the core in reset through a chain of timed stages before letting it run. Power-on and brown-out detect pulses, a filtered external master-clear pin, a watchdog expiry, a software reset request and the two stack-error strobes are the sources. Each accepted request leaves a cause code and two event flags that firmware reads after restart.

The release chain depends on the cause and on the configured oscillator mode. A power-up delay, counted on a slow free-running tick, applies only after power-on or brown-out and only when enabled. Next comes an oscillator settle count of oscillator clock cycles, which applies only in the crystal and resonator modes. In the high-speed PLL mode, a PLL lock wait on the slow tick follows. The same mode decides whether the system clock select picks the times-four PLL path.

A watchdog expiry while the core sleeps is a wake-up and leaves the core running. A new reset request during a running chain restarts the chain from the first stage that applies to the new cause. The synchronous `rst` input acts as the power-on condition.

Top module: `rstseq_ctrl`

## Requirements
- R1: Each accepted request asserts `core_rst` and loads `rst_cause` with its code: 1 power-on, 2 master-clear while running, 3 master-clear while sleeping, 4 watchdog while running, 5 watchdog wake from sleep, 6 brown-out, 7 software request, 8 stack full, 9 stack underflow.
- R2: When requests arrive in the same cycle, only one is recorded, with precedence power-on, brown-out, master-clear, watchdog, software, stack full, stack underflow.
- R3: `flag_to` is 1 after codes 4 and 5 and 0 after any other code; `flag_pd` is 1 after codes 3 and 5 and 0 after any other code.
- R4: A watchdog expiry with `cpu_sleeping` high and no other request sets code 5 and leaves `core_rst` low.
- R5: Master-clear asserts only after `mclr_n` has been seen low on MCLR_SAMPLES consecutive `lp_tick` samples. A shorter low pulse changes neither `core_rst` nor `rst_cause`. The core stays in reset while the filtered pin stays low.
- R6: The power-up delay of PWRT_TICKS `lp_tick` pulses runs first, only after power-on or brown-out and only when `pwrt_en` is 1.
- R7: In oscillator modes 0, 1, 2 and 6, the release waits OST_CYCLES clock cycles for oscillator settling. In modes 3, 4, 5 and 7 this stage is skipped.
- R8: In mode 6, a PLL lock wait of PLL_TICKS `lp_tick` pulses follows the oscillator stage before `core_rst` falls.
- R9: `clk_sel_pll` is 1 exactly when `osc_mode` was 6 in the previous cycle.
- R10: A new request during a running release chain restarts the chain from the first stage that applies to that request.
- R11: While `rst` is high, `core_rst` is 1, `rst_cause` is 1, both flags are 0 and `clk_sel_pll` is 0. After `rst` falls, a power-on release chain follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset, treated as power-on |
| por_pulse | input | 1 | Power-on detect strobe |
| bor_pulse | input | 1 | Brown-out detect strobe |
| mclr_n | input | 1 | External master-clear pin, active low, asynchronous |
| wdt_expire | input | 1 | Watchdog time-out strobe |
| soft_rst_req | input | 1 | Software reset request strobe |
| stk_full | input | 1 | Stack overflow strobe |
| stk_under | input | 1 | Stack underflow strobe |
| cpu_sleeping | input | 1 | Core is in sleep |
| osc_mode | input | 3 | Oscillator mode configuration, 6 = high-speed PLL |
| pwrt_en | input | 1 | Power-up delay enable |
| lp_tick | input | 1 | One-cycle pulse from the slow timebase |
| core_rst | output | 1 | Core reset, active high |
| clk_sel_pll | output | 1 | System clock select, 1 = times-four PLL |
| rst_cause | output | 4 | Code of the last accepted event |
| flag_to | output | 1 | Watchdog event flag |
| flag_pd | output | 1 | Sleep event flag |

## Verification
The release length is measured from each trigger under several combinations of cause, mode and delay enable. A power-on pulse in an external-clock mode, a brown-out in the PLL mode and software requests in crystal and external-clock modes each give a different duration, so a stage that is missing, misplaced or applied to the wrong cause shows up as a wrong length. Master-clear is tried with a short glitch, a long low level while running and a long low level while sleeping, which separates the filter from the cause encoding. Simultaneous strobes check precedence, a watchdog expiry during sleep checks the wake path, and a software request partway through the oscillator stage checks the restart.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [3:0] {
    CS_NONE      = 4'd0,
    CS_POR       = 4'd1,
    CS_MCLR_RUN  = 4'd2,
    CS_MCLR_SLP  = 4'd3,
    CS_WDT_RUN   = 4'd4,
    CS_WDT_WAKE  = 4'd5,
    CS_BOR       = 4'd6,
    CS_SWRST     = 4'd7,
    CS_STKFULL   = 4'd8,
    CS_STKUNF    = 4'd9
  } cause_e;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_PWRT,
    ST_OST,
    ST_PLL,
    ST_RUN
  } stage_e;

  typedef struct packed {
    logic   valid;
    logic   wake;
    logic   power;
    cause_e code;
  } evt_t;

  localparam logic [2:0] MODE_HSPLL = 3'd6;

  // crystal / resonator modes need the oscillator settle count
  function automatic logic needs_ost(input logic [2:0] mode);
    return (mode == 3'd0) || (mode == 3'd1) || (mode == 3'd2) || (mode == MODE_HSPLL);
  endfunction

endpackage

// File: rtl/rstseq_pin_filter.sv
module rstseq_pin_filter #(
  parameter int SAMPLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic tick,
  output logic pin_low,
  output logic hold
);
  localparam int CW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

  logic          sync1, sync2;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= pin_n;
      sync2 <= sync1;
    end
  end

  assign pin_low = ~sync2;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      hold    <= 1'b0;
    end else if (tick) begin
      if (!sync2) begin
        if (run_cnt == LAST) begin
          hold <= 1'b1;
        end else begin
          run_cnt <= run_cnt + 1'b1;
        end
      end else begin
        run_cnt <= '0;
        hold    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rstseq_cause_enc.sv
module rstseq_cause_enc
  import rstseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       por,
  input  logic       bor,
  input  logic       mclr_rise,
  input  logic       wdt,
  input  logic       sw,
  input  logic       sfull,
  input  logic       sunder,
  input  logic       sleeping,
  output evt_t       evt,
  output logic [3:0] cause_o,
  output logic       to_o,
  output logic       pd_o
);
  cause_e cause_q;

  // fixed precedence, highest first
  always_comb begin
    evt = '0;
    if (por) begin
      evt.valid = 1'b1;
      evt.power = 1'b1;
      evt.code  = CS_POR;
    end else if (bor) begin
      evt.valid = 1'b1;
      evt.power = 1'b1;
      evt.code  = CS_BOR;
    end else if (mclr_rise) begin
      evt.valid = 1'b1;
      evt.code  = sleeping ? CS_MCLR_SLP : CS_MCLR_RUN;
    end else if (wdt) begin
      evt.valid = 1'b1;
      evt.wake  = sleeping;
      evt.code  = sleeping ? CS_WDT_WAKE : CS_WDT_RUN;
    end else if (sw) begin
      evt.valid = 1'b1;
      evt.code  = CS_SWRST;
    end else if (sfull) begin
      evt.valid = 1'b1;
      evt.code  = CS_STKFULL;
    end else if (sunder) begin
      evt.valid = 1'b1;
      evt.code  = CS_STKUNF;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= CS_POR;
      to_o    <= 1'b0;
      pd_o    <= 1'b0;
    end else if (evt.valid) begin
      cause_q <= evt.code;
      to_o    <= (evt.code == CS_WDT_RUN) || (evt.code == CS_WDT_WAKE);
      pd_o    <= (evt.code == CS_MCLR_SLP) || (evt.code == CS_WDT_WAKE);
    end
  end

  assign cause_o = cause_q;

endmodule

// File: rtl/rstseq_stage_seq.sv
module rstseq_stage_seq
  import rstseq_pkg::*;
#(
  parameter int PWRT_TICKS = 72,
  parameter int OST_CYCLES = 1024,
  parameter int PLL_TICKS  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       start_power,
  input  logic       hold,
  input  logic [2:0] osc_mode,
  input  logic       pwrt_en,
  input  logic       tick,
  output logic       core_rst_o,
  output logic       pll_sel_o
);
  localparam int MAXA = (PWRT_TICKS > OST_CYCLES) ? PWRT_TICKS : OST_CYCLES;
  localparam int MAXC = (MAXA > PLL_TICKS) ? MAXA : PLL_TICKS;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PWRT_LAST = CW'(PWRT_TICKS - 1);
  localparam logic [CW-1:0] OST_LAST  = CW'(OST_CYCLES - 1);
  localparam logic [CW-1:0] PLL_LAST  = CW'(PLL_TICKS - 1);

  stage_e        st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          pend, pend_n;
  stage_e        after_pwrt, after_ost;
  logic          is_pll_mode;

  assign is_pll_mode = (osc_mode == MODE_HSPLL);
  assign after_ost   = is_pll_mode ? ST_PLL : ST_RUN;
  assign after_pwrt  = needs_ost(osc_mode) ? ST_OST : after_ost;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    pend_n = pend;
    if (start) begin
      st_n   = ST_HOLD;
      cnt_n  = '0;
      pend_n = start_power;
    end else if (hold) begin
      st_n  = ST_HOLD;
      cnt_n = '0;
    end else begin
      case (st)
        ST_HOLD: begin
          cnt_n = '0;
          st_n  = (pend && pwrt_en) ? ST_PWRT : after_pwrt;
        end
        ST_PWRT: begin
          if (tick) begin
            if (cnt == PWRT_LAST) begin
              st_n  = after_pwrt;
              cnt_n = '0;
            end else begin
              cnt_n = cnt + 1'b1;
            end
          end
        end
        ST_OST: begin
          if (cnt == OST_LAST) begin
            st_n  = after_ost;
            cnt_n = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        ST_PLL: begin
          if (tick) begin
            if (cnt == PLL_LAST) begin
              st_n  = ST_RUN;
              cnt_n = '0;
            end else begin
              cnt_n = cnt + 1'b1;
            end
          end
        end
        default: begin
          pend_n = 1'b0;
          cnt_n  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_HOLD;
      cnt        <= '0;
      pend       <= 1'b1;
      core_rst_o <= 1'b1;
      pll_sel_o  <= 1'b0;
    end else begin
      st         <= st_n;
      cnt        <= cnt_n;
      pend       <= pend_n;
      core_rst_o <= (st_n != ST_RUN);
      pll_sel_o  <= is_pll_mode;
    end
  end

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int PWRT_TICKS   = 72,
  parameter int OST_CYCLES   = 1024,
  parameter int PLL_TICKS    = 2,
  parameter int MCLR_SAMPLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       por_pulse,
  input  logic       bor_pulse,
  input  logic       mclr_n,
  input  logic       wdt_expire,
  input  logic       soft_rst_req,
  input  logic       stk_full,
  input  logic       stk_under,
  input  logic       cpu_sleeping,
  input  logic [2:0] osc_mode,
  input  logic       pwrt_en,
  input  logic       lp_tick,
  output logic       core_rst,
  output logic       clk_sel_pll,
  output logic [3:0] rst_cause,
  output logic       flag_to,
  output logic       flag_pd
);
  logic mclr_hold, mclr_hold_q, mclr_low, mclr_rise;
  evt_t evt;
  logic seq_start;

  rstseq_pin_filter #(.SAMPLES(MCLR_SAMPLES)) u_filt (
    .clk     (clk),
    .rst     (rst),
    .pin_n   (mclr_n),
    .tick    (lp_tick),
    .pin_low (mclr_low),
    .hold    (mclr_hold)
  );

  always_ff @(posedge clk) begin
    if (rst) mclr_hold_q <= 1'b0;
    else     mclr_hold_q <= mclr_hold;
  end

  assign mclr_rise = mclr_hold & ~mclr_hold_q;

  rstseq_cause_enc u_cause (
    .clk       (clk),
    .rst       (rst),
    .por       (por_pulse),
    .bor       (bor_pulse),
    .mclr_rise (mclr_rise),
    .wdt       (wdt_expire),
    .sw        (soft_rst_req),
    .sfull     (stk_full),
    .sunder    (stk_under),
    .sleeping  (cpu_sleeping),
    .evt       (evt),
    .cause_o   (rst_cause),
    .to_o      (flag_to),
    .pd_o      (flag_pd)
  );

  assign seq_start = evt.valid & ~evt.wake;

  rstseq_stage_seq #(
    .PWRT_TICKS (PWRT_TICKS),
    .OST_CYCLES (OST_CYCLES),
    .PLL_TICKS  (PLL_TICKS)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (seq_start),
    .start_power (evt.power),
    .hold        (mclr_hold),
    .osc_mode    (osc_mode),
    .pwrt_en     (pwrt_en),
    .tick        (lp_tick),
    .core_rst_o  (core_rst),
    .pll_sel_o   (clk_sel_pll)
  );

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk
  import rstseq_pkg::*;
#(
  parameter int OST_CYCLES = 1024
) (
  input logic       clk,
  input logic       rst,
  input logic       core_rst,
  input logic       clk_sel_pll,
  input logic [2:0] osc_mode,
  input logic       por_pulse,
  input logic       bor_pulse,
  input logic       wdt_expire,
  input logic       soft_rst_req,
  input logic       stk_full,
  input logic       stk_under,
  input logic       cpu_sleeping,
  input logic       mclr_hold,
  input logic       mclr_low,
  input logic [3:0] rst_cause,
  input logic       flag_to,
  input logic       flag_pd
);
  localparam int HW = $clog2(OST_CYCLES + 1);
  localparam logic [HW-1:0] HMAX = HW'(OST_CYCLES);

  logic [HW-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else if (core_rst) held <= (held == HMAX) ? held : held + 1'b1;
    else held <= '0;
  end

  AST_RESET_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst) |-> $past(por_pulse || bor_pulse || mclr_hold || (wdt_expire && !cpu_sleeping)
                              || soft_rst_req || stk_full || stk_under)); // R1

  AST_WAKE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (rst_cause == CS_WDT_WAKE) |-> (flag_to && flag_pd)); // R3

  AST_WAKE_KEEPS_RUN: assert property (@(posedge clk) disable iff (rst)
    (!core_rst && wdt_expire && cpu_sleeping && !por_pulse && !bor_pulse && !soft_rst_req
     && !stk_full && !stk_under && !mclr_hold) |=> !core_rst); // R4

  AST_FILTER_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(mclr_hold) |-> $past(mclr_low)); // R5

  AST_OST_MIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($fell(core_rst) && needs_ost($past(osc_mode))) |-> (held == HMAX)); // R7

  AST_PLL_SEL_MODE: assert property (@(posedge clk) disable iff (rst)
    clk_sel_pll |-> ($past(osc_mode) == MODE_HSPLL)); // R9

endmodule

bind rstseq_ctrl rstseq_chk #(.OST_CYCLES(OST_CYCLES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .core_rst     (core_rst),
  .clk_sel_pll  (clk_sel_pll),
  .osc_mode     (osc_mode),
  .por_pulse    (por_pulse),
  .bor_pulse    (bor_pulse),
  .wdt_expire   (wdt_expire),
  .soft_rst_req (soft_rst_req),
  .stk_full     (stk_full),
  .stk_under    (stk_under),
  .cpu_sleeping (cpu_sleeping),
  .mclr_hold    (mclr_hold),
  .mclr_low     (mclr_low),
  .rst_cause    (rst_cause),
  .flag_to      (flag_to),
  .flag_pd      (flag_pd)
);

// File: tb/rstseq_ctrl_test.sv
module rstseq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       por_pulse = 1'b0, bor_pulse = 1'b0, mclr_n = 1'b1;
  logic       wdt_expire = 1'b0, soft_rst_req = 1'b0;
  logic       stk_full = 1'b0, stk_under = 1'b0, cpu_sleeping = 1'b0;
  logic [2:0] osc_mode = 3'd1;
  logic       pwrt_en = 1'b1;
  logic       lp_tick = 1'b0;
  logic       core_rst, clk_sel_pll, flag_to, flag_pd;
  logic [3:0] rst_cause;

  int n_chk = 0;
  int n_fail = 0;

  rstseq_ctrl #(
    .PWRT_TICKS   (8),
    .OST_CYCLES   (64),
    .PLL_TICKS    (4),
    .MCLR_SAMPLES (4)
  ) uut (
    .clk(clk), .rst(rst), .por_pulse(por_pulse), .bor_pulse(bor_pulse), .mclr_n(mclr_n),
    .wdt_expire(wdt_expire), .soft_rst_req(soft_rst_req), .stk_full(stk_full),
    .stk_under(stk_under), .cpu_sleeping(cpu_sleeping), .osc_mode(osc_mode),
    .pwrt_en(pwrt_en), .lp_tick(lp_tick), .core_rst(core_rst), .clk_sel_pll(clk_sel_pll),
    .rst_cause(rst_cause), .flag_to(flag_to), .flag_pd(flag_pd)
  );

  always #10 clk = ~clk;

  // slow timebase: one tick every fourth cycle
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      ph = ph + 1;
      lp_tick = ((ph % 4) == 0);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input string what, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  // 1 por, 2 bor, 3 wdt, 4 sw, 5 stack full, 6 stack under
  task automatic fire(input int a, input int b);
    @(negedge clk);
    por_pulse    = (a == 1) || (b == 1);
    bor_pulse    = (a == 2) || (b == 2);
    wdt_expire   = (a == 3) || (b == 3);
    soft_rst_req = (a == 4) || (b == 4);
    stk_full     = (a == 5) || (b == 5);
    stk_under    = (a == 6) || (b == 6);
    @(negedge clk);
    por_pulse = 0; bor_pulse = 0; wdt_expire = 0; soft_rst_req = 0; stk_full = 0; stk_under = 0;
  endtask

  task automatic wait_release(output int n);
    n = 0;
    while (core_rst && n < 3000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    int n;
    repeat (3) @(negedge clk);
    chk("R11", "core_rst in rst", core_rst, 1);
    chk("R11", "cause in rst", rst_cause, 1);
    chk("R11", "flags in rst", {flag_to, flag_pd}, 0);
    chk("R11", "pll sel in rst", clk_sel_pll, 0);
    rst = 1'b0;
    @(negedge clk);
    wait_release(n);
    chk_range("R6", "release after rst, XT, delay on", n, 88, 110);
  endtask

  task automatic t_por_nopwrt;
    int n;
    pwrt_en = 0; osc_mode = 3'd1;
    fire(1, 0);
    chk("R1", "por cause", rst_cause, 1);
    wait_release(n);
    chk_range("R7", "por XT delay off", n, 62, 70);
  endtask

  task automatic t_bor_pll;
    int n;
    pwrt_en = 1; osc_mode = 3'd6;
    fire(2, 0);
    chk("R1", "bor cause", rst_cause, 6);
    wait_release(n);
    chk_range("R8", "bor PLL mode release", n, 100, 128);
    chk("R9", "pll select in mode 6", clk_sel_pll, 1);
  endtask

  task automatic t_sw_ec;
    int n;
    osc_mode = 3'd4;
    fire(4, 0);
    chk("R1", "sw cause", rst_cause, 7);
    wait_release(n);
    chk_range("R7", "sw ext clock skips settle", n, 1, 2);
    chk("R9", "pll select in mode 4", clk_sel_pll, 0);
  endtask

  task automatic t_por_ec;
    int n;
    osc_mode = 3'd4; pwrt_en = 1;
    fire(1, 0);
    wait_release(n);
    chk_range("R6", "por ext clock delay only", n, 28, 40);
  endtask

  task automatic t_sw_xt;
    int n;
    osc_mode = 3'd1; pwrt_en = 1;
    fire(4, 0);
    wait_release(n);
    chk_range("R6", "sw skips power-up delay", n, 62, 70);
  endtask

  task automatic t_wdt_run;
    int n;
    fire(3, 0);
    chk("R1", "wdt run cause", rst_cause, 4);
    chk("R3", "wdt run flags to,pd", {flag_to, flag_pd}, 2);
    chk("R1", "wdt run asserts reset", core_rst, 1);
    wait_release(n);
    chk_range("R7", "wdt run release", n, 62, 70);
  endtask

  task automatic t_wdt_wake;
    int hi;
    hi = 0;
    cpu_sleeping = 1;
    fire(3, 0);
    repeat (12) begin
      @(negedge clk);
      if (core_rst) hi++;
    end
    chk("R4", "wake reset cycles", hi, 0);
    chk("R4", "wake cause", rst_cause, 5);
    chk("R3", "wake flags to,pd", {flag_to, flag_pd}, 3);
    cpu_sleeping = 0;
  endtask

  task automatic t_glitch;
    int hi;
    hi = 0;
    @(negedge clk);
    mclr_n = 0;
    repeat (10) @(negedge clk);
    mclr_n = 1;
    repeat (30) begin
      @(negedge clk);
      if (core_rst) hi++;
    end
    chk("R5", "glitch reset cycles", hi, 0);
    chk("R5", "glitch cause kept", rst_cause, 5);
  endtask

  task automatic t_mclr(input bit slp);
    int n;
    cpu_sleeping = slp;
    @(negedge clk);
    mclr_n = 0;
    repeat (40) @(negedge clk);
    chk("R5", "mclr held reset", core_rst, 1);
    chk("R1", "mclr cause", rst_cause, slp ? 3 : 2);
    chk("R3", "mclr flags to,pd", {flag_to, flag_pd}, slp ? 1 : 0);
    mclr_n = 1;
    cpu_sleeping = 0;
    wait_release(n);
    chk_range("R5", "mclr release after pin high", n, 62, 80);
  endtask

  task automatic t_priority;
    int n;
    fire(3, 4);
    chk("R2", "wdt over sw", rst_cause, 4);
    wait_release(n);
    fire(5, 6);
    chk("R2", "full over under", rst_cause, 8);
    wait_release(n);
    fire(6, 0);
    chk("R1", "underflow cause", rst_cause, 9);
    wait_release(n);
    fire(2, 4);
    chk("R2", "bor over sw", rst_cause, 6);
    wait_release(n);
  endtask

  task automatic t_restart;
    int n;
    osc_mode = 3'd1; pwrt_en = 0;
    fire(1, 0);
    repeat (30) @(negedge clk);
    fire(4, 0);
    chk("R10", "restart cause", rst_cause, 7);
    wait_release(n);
    chk_range("R10", "restart full settle", n, 62, 70);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_por_nopwrt();
    t_bor_pll();
    t_sw_ec();
    t_por_ec();
    t_sw_xt();
    t_wdt_run();
    t_wdt_wake();
    t_glitch();
    t_mclr(1'b1);
    t_mclr(1'b0);
    t_priority();
    t_restart();
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule